// File: doc/BRIEF.md
# Asynchronous Pulse Time Tagger

This block records the absolute time at which a rising edge appears on an input line that is asynchronous to both of its clocks. The line is brought into the reference clock domain through a chain of synchroniser flops, and a rising edge is detected there. On the capture edge, the block latches the running time from the reference time inputs. That time is a seconds count plus a count of reference clock cycles within the second, and the reference clock runs at 125 MHz by default.

The latched tag then crosses into the system clock domain. A toggle request and a toggle acknowledge carry the handshake, and the tag register holds still until the system side has copied it. On the system side, the tag appears on registered outputs together with a one-cycle strobe. An optional interrupt pulse accompanies the strobe when it is enabled. Edges that arrive while the time is marked invalid are dropped. Edges that arrive while an earlier tag is still in flight are also dropped.

Top module: `ts_stamper_top`

## Requirements
- R1: While `rst` is high and after its release, `tag_stb` and `irq_out` are 0 and `tag_sec` and `tag_cyc` are 0 until the first tag is delivered.
- R2: A rising edge on `pulse_in` that is stable over a whole reference period yields a tag equal to the `time_sec`/`time_cyc` values sampled on the third rising edge of `clk_ref` after the input edge. The first two edges are synchroniser stages and the third is the capture.
- R3: Each delivered tag comes with `tag_stb` high for exactly one `clk_sys` cycle. `tag_sec` and `tag_cyc` change only in the cycle in which `tag_stb` is high.
- R4: No tag is produced for an edge when `time_ok` is low on the capture edge.
- R5: Only 0-to-1 transitions of `pulse_in` are tagged. A falling edge, or a level held high, produces no further tag.
- R6: A rising edge reaching capture while an earlier tag is still crossing domains is ignored. Once the acknowledge has returned, new edges are tagged again.
- R7: `irq_out` is high in exactly the cycles where `tag_stb` is high and `irq_en` is 1. It stays 0 when `irq_en` is 0.
- R8: The captured tag held in the reference domain does not change from capture until the acknowledge from the system domain has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that carries the running time |
| clk_sys | input | 1 | System clock of the tag outputs |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| pulse_in | input | 1 | Asynchronous pulse to be tagged |
| time_ok | input | 1 | High when the reference time is valid (reference domain) |
| time_sec | input | SEC_W | Seconds part of the running time (reference domain) |
| time_cyc | input | CYC_W | Reference-cycle count within the second (reference domain) |
| irq_en | input | 1 | Enables `irq_out` pulses (system domain) |
| tag_sec | output | SEC_W | Seconds of the last tag |
| tag_cyc | output | CYC_W | Cycle count of the last tag |
| tag_stb | output | 1 | One-cycle strobe marking a new tag |
| irq_out | output | 1 | Interrupt pulse accompanying the strobe when enabled |

## Verification
The captured value is fixed exactly: the tag's cycle count is the bench's reference counter two increments after the reference period in which the pulse was raised. The bench drives the pulse at a falling reference edge and computes that value with its own function. The strobe itself arrives after a variable number of system cycles, set by the phase between the two clocks through three sys registers. The bench therefore waits a fixed window of 60 system cycles, far longer than the worst-case crossing, and then compares the strobe count and the last tag. Strobe width, tag stability and the interrupt are watched every system cycle at the falling clock edge.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int TS_SEC_W_DEF  = 40;
  localparam int TS_CYC_W_DEF  = 28;
  localparam int TS_SYNC_N_DEF = 2;
  localparam int TS_REF_HZ_DEF = 125_000_000;

  function automatic logic ts_rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/ts_sync_bit.sv
module ts_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ts_ref_capture.sv
module ts_ref_capture
  import ts_pkg::*;
#(
  parameter int SEC_W = TS_SEC_W_DEF,
  parameter int CYC_W = TS_CYC_W_DEF
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             pulse_s,
  input  logic             time_ok,
  input  logic [SEC_W-1:0] time_sec,
  input  logic [CYC_W-1:0] time_cyc,
  input  logic             ack_s,
  output logic             req_tgl,
  output logic             busy,
  output logic [SEC_W-1:0] hold_sec,
  output logic [CYC_W-1:0] hold_cyc
);
  logic pulse_prev;
  logic take;

  assign busy = req_tgl ^ ack_s;
  assign take = ts_rise(pulse_s, pulse_prev) & time_ok & ~busy;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      pulse_prev <= 1'b0;
      req_tgl    <= 1'b0;
      hold_sec   <= '0;
      hold_cyc   <= '0;
    end else begin
      pulse_prev <= pulse_s;
      if (take) begin
        hold_sec <= time_sec;
        hold_cyc <= time_cyc;
        req_tgl  <= ~req_tgl;
      end
    end
  end
endmodule

// File: rtl/ts_sys_deliver.sv
module ts_sys_deliver
  import ts_pkg::*;
#(
  parameter int SEC_W = TS_SEC_W_DEF,
  parameter int CYC_W = TS_CYC_W_DEF
) (
  input  logic             clk_sys,
  input  logic             rst,
  input  logic             req_s,
  input  logic             irq_en,
  input  logic [SEC_W-1:0] hold_sec,
  input  logic [CYC_W-1:0] hold_cyc,
  output logic             ack_tgl,
  output logic [SEC_W-1:0] tag_sec,
  output logic [CYC_W-1:0] tag_cyc,
  output logic             tag_stb,
  output logic             irq_out
);
  logic req_seen;
  logic fresh;

  assign fresh = req_s ^ req_seen;

  always_ff @(posedge clk_sys) begin
    if (rst) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      tag_sec  <= '0;
      tag_cyc  <= '0;
      tag_stb  <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      req_seen <= req_s;
      tag_stb  <= fresh;
      irq_out  <= fresh & irq_en;
      if (fresh) begin
        tag_sec <= hold_sec;
        tag_cyc <= hold_cyc;
        ack_tgl <= req_s;
      end
    end
  end
endmodule

// File: rtl/ts_stamper_top.sv
module ts_stamper_top
  import ts_pkg::*;
#(
  parameter int SEC_W  = TS_SEC_W_DEF,
  parameter int CYC_W  = TS_CYC_W_DEF,
  parameter int SYNC_N = TS_SYNC_N_DEF
) (
  input  logic             clk_ref,
  input  logic             clk_sys,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic             time_ok,
  input  logic [SEC_W-1:0] time_sec,
  input  logic [CYC_W-1:0] time_cyc,
  input  logic             irq_en,
  output logic [SEC_W-1:0] tag_sec,
  output logic [CYC_W-1:0] tag_cyc,
  output logic             tag_stb,
  output logic             irq_out
);
  logic             pulse_s;
  logic             req_tgl;
  logic             req_s;
  logic             ack_tgl;
  logic             ack_s;
  logic             busy;
  logic [SEC_W-1:0] hold_sec;
  logic [CYC_W-1:0] hold_cyc;

  ts_sync_bit #(.STAGES(SYNC_N)) u_pulse_sync (
    .clk(clk_ref), .rst(rst), .d(pulse_in), .q(pulse_s));

  ts_sync_bit #(.STAGES(SYNC_N)) u_ack_sync (
    .clk(clk_ref), .rst(rst), .d(ack_tgl), .q(ack_s));

  ts_sync_bit #(.STAGES(SYNC_N)) u_req_sync (
    .clk(clk_sys), .rst(rst), .d(req_tgl), .q(req_s));

  ts_ref_capture #(.SEC_W(SEC_W), .CYC_W(CYC_W)) u_cap (
    .clk_ref(clk_ref), .rst(rst), .pulse_s(pulse_s), .time_ok(time_ok),
    .time_sec(time_sec), .time_cyc(time_cyc), .ack_s(ack_s),
    .req_tgl(req_tgl), .busy(busy), .hold_sec(hold_sec), .hold_cyc(hold_cyc));

  ts_sys_deliver #(.SEC_W(SEC_W), .CYC_W(CYC_W)) u_dlv (
    .clk_sys(clk_sys), .rst(rst), .req_s(req_s), .irq_en(irq_en),
    .hold_sec(hold_sec), .hold_cyc(hold_cyc), .ack_tgl(ack_tgl),
    .tag_sec(tag_sec), .tag_cyc(tag_cyc), .tag_stb(tag_stb), .irq_out(irq_out));
endmodule

// File: rtl/ts_stamper_chk.sv
module ts_stamper_chk #(
  parameter int SEC_W = 40,
  parameter int CYC_W = 28
) (
  input logic             clk_ref,
  input logic             clk_sys,
  input logic             rst,
  input logic             time_ok,
  input logic             req_tgl,
  input logic             busy,
  input logic [SEC_W-1:0] hold_sec,
  input logic [CYC_W-1:0] hold_cyc,
  input logic [SEC_W-1:0] tag_sec,
  input logic [CYC_W-1:0] tag_cyc,
  input logic             tag_stb,
  input logic             irq_out
);
  assert_stb_one_cycle_R3: assert property (@(posedge clk_sys) disable iff (rst)
    tag_stb |=> !tag_stb);

  assert_tag_still_R3: assert property (@(posedge clk_sys) disable iff (rst)
    !tag_stb |-> ($stable(tag_sec) && $stable(tag_cyc)));

  assert_irq_needs_stb_R7: assert property (@(posedge clk_sys) disable iff (rst)
    irq_out |-> tag_stb);

  assert_no_take_invalid_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (req_tgl != $past(req_tgl)) |-> $past(time_ok));

  assert_no_take_busy_R6: assert property (@(posedge clk_ref) disable iff (rst)
    (req_tgl != $past(req_tgl)) |-> !$past(busy));

  assert_hold_still_R8: assert property (@(posedge clk_ref) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(hold_sec) && $stable(hold_cyc)));
endmodule

bind ts_stamper_top ts_stamper_chk #(.SEC_W(SEC_W), .CYC_W(CYC_W)) chk_i (
  .clk_ref(clk_ref), .clk_sys(clk_sys), .rst(rst), .time_ok(time_ok),
  .req_tgl(req_tgl), .busy(busy), .hold_sec(hold_sec), .hold_cyc(hold_cyc),
  .tag_sec(tag_sec), .tag_cyc(tag_cyc), .tag_stb(tag_stb), .irq_out(irq_out));

// File: tb/ts_stamper_top_tb_top.sv
`timescale 1ns/1ps
module ts_stamper_top_tb_top;
  localparam int SEC_W = 40;
  localparam int CYC_W = 28;

  logic             clk_ref = 0;
  logic             clk_sys = 0;
  logic             rst = 1;
  logic             pulse_in = 0;
  logic             time_ok = 0;
  logic [SEC_W-1:0] time_sec = '0;
  logic [CYC_W-1:0] time_cyc = '0;
  logic             irq_en = 0;
  logic [SEC_W-1:0] tag_sec;
  logic [CYC_W-1:0] tag_cyc;
  logic             tag_stb;
  logic             irq_out;

  int checks = 0;
  int fails = 0;
  int stb_count = 0;
  int mon_bad_r3 = 0;
  int mon_bad_r7 = 0;
  bit done = 0;
  logic             prev_stb = 0;
  logic [SEC_W-1:0] prev_sec = '0;
  logic [CYC_W-1:0] prev_cyc = '0;
  bit               mon_on = 0;

  always #10 clk_sys = ~clk_sys;
  always #4  clk_ref = ~clk_ref;

  always @(posedge clk_ref) time_cyc <= time_cyc + 1'b1;

  ts_stamper_top dut_i (
    .clk_ref(clk_ref), .clk_sys(clk_sys), .rst(rst), .pulse_in(pulse_in),
    .time_ok(time_ok), .time_sec(time_sec), .time_cyc(time_cyc), .irq_en(irq_en),
    .tag_sec(tag_sec), .tag_cyc(tag_cyc), .tag_stb(tag_stb), .irq_out(irq_out));

  function automatic logic [CYC_W-1:0] exp_cyc(input logic [CYC_W-1:0] c_at_raise);
    return c_at_raise + CYC_W'(2);
  endfunction

  always @(negedge clk_sys) begin
    if (mon_on) begin
      if (tag_stb) stb_count++;
      if (tag_stb && prev_stb) mon_bad_r3++;
      if (!tag_stb && (tag_sec != prev_sec || tag_cyc != prev_cyc)) mon_bad_r3++;
      if (irq_out != (tag_stb & irq_en)) mon_bad_r7++;
    end
    prev_stb = tag_stb;
    prev_sec = tag_sec;
    prev_cyc = tag_cyc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic raise(input int high_cycles, output logic [CYC_W-1:0] c0);
    @(negedge clk_ref);
    c0 = time_cyc;
    pulse_in = 1;
    repeat (high_cycles) @(negedge clk_ref);
    pulse_in = 0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk_sys);
  endtask

  task automatic set_sec(input logic [SEC_W-1:0] v);
    @(negedge clk_ref);
    time_sec = v;
  endtask

  initial begin
    logic [CYC_W-1:0] c0;
    logic [CYC_W-1:0] c1;
    int n0;
    void'($urandom(32'd4242));
    repeat (10) @(negedge clk_sys);
    // R1: reset values
    check(tag_stb == 0 && irq_out == 0, "R1", "strobe/irq in reset", {tag_stb, irq_out}, 0);
    check(tag_sec == 0 && tag_cyc == 0, "R1", "tag in reset", tag_cyc, 0);
    rst = 0;
    mon_on = 1;
    repeat (5) @(negedge clk_sys);
    check(tag_stb == 0 && tag_sec == 0 && tag_cyc == 0, "R1", "after release", tag_cyc, 0);

    // R4: time invalid, edge dropped
    time_ok = 0;
    n0 = stb_count;
    raise(3, c0);
    settle();
    check(stb_count == n0, "R4", "tags while invalid", stb_count - n0, 0);
    check(tag_cyc == 0, "R4", "tag untouched while invalid", tag_cyc, 0);

    // R2/R7: directed capture with irq enabled
    time_ok = 1;
    irq_en = 1;
    set_sec(40'hAB_CDEF_0123);
    n0 = stb_count;
    raise(1, c0);
    settle();
    check(stb_count == n0 + 1, "R2", "one tag", stb_count - n0, 1);
    check(tag_cyc == exp_cyc(c0), "R2", "cycles", tag_cyc, exp_cyc(c0));
    check(tag_sec == 40'hAB_CDEF_0123, "R2", "seconds", tag_sec, 40'hAB_CDEF_0123);

    // R5: held high then falling edge
    irq_en = 0;
    n0 = stb_count;
    raise(40, c0);
    check(stb_count == n0 + 1, "R5", "level held high gives one tag", stb_count - n0, 1);
    settle();
    check(stb_count == n0 + 1, "R5", "falling edge gives none", stb_count - n0, 1);
    check(tag_cyc == exp_cyc(c0), "R5", "tag of rising edge", tag_cyc, exp_cyc(c0));

    // R6: second edge while first in flight
    n0 = stb_count;
    raise(2, c0);
    repeat (2) @(negedge clk_ref);
    raise(2, c1);
    settle();
    check(stb_count == n0 + 1, "R6", "edge during flight ignored", stb_count - n0, 1);
    check(tag_cyc == exp_cyc(c0), "R6", "first edge kept", tag_cyc, exp_cyc(c0));
    n0 = stb_count;
    raise(2, c1);
    settle();
    check(stb_count == n0 + 1 && tag_cyc == exp_cyc(c1), "R6", "accepted after ack",
          tag_cyc, exp_cyc(c1));

    // random trials
    for (int t = 0; t < 24; t++) begin
      logic [SEC_W-1:0] s;
      s = {$urandom(), $urandom()};
      irq_en = $urandom_range(0, 1);
      set_sec(s);
      repeat ($urandom_range(0, 7)) @(negedge clk_ref);
      n0 = stb_count;
      raise($urandom_range(1, 6), c0);
      settle();
      check(stb_count == n0 + 1, "R2", "random tag count", stb_count - n0, 1);
      check(tag_cyc == exp_cyc(c0) && tag_sec == s, "R2", "random tag", tag_cyc, exp_cyc(c0));
    end

    check(mon_bad_r3 == 0, "R3", "strobe width / tag stability", mon_bad_r3, 0);
    check(mon_bad_r7 == 0, "R7", "irq follows strobe and enable", mon_bad_r7, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_sys);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule